// File: doc/BRIEF.md
# Sector Erase Queue Controller

This block sits between a flash command decoder and the erase engine. A decoded sector erase command opens an acceptance window. While the window is open, further sector erase commands add their sector to a bitmap, and each one restarts the window. When the window runs out with no new command, the block gives the bitmap to the erase engine with a one-cycle start pulse. A status bit then reports that the window has closed.

Three kinds of command act on the window. Any foreign command while the window is open throws the queue away and returns the device to array reads. An erase suspend while the window is open suspends at once. An erase suspend during a running erase takes effect after a fixed latency counted in microsecond ticks. While the block is suspended, the array can be accessed, but any read or program aimed at a queued sector is flagged as not allowed. An erase resume restarts the engine on the same bitmap. When the engine reports completion, the bitmap is released and the block signals a return to read mode.

Top module: `sect_erase_queue`

## Requirements
- R1: After reset the block is idle: sectorMask is all zero and eraseStart, suspended, windowExpired, busy, readMode and accessDenied are all low.
- R2: A sector erase command while idle opens the window on the next cycle. Bit i of sectorMask is set for sector index i, busy goes high and windowExpired stays low.
- R3: While the window is open, further sector erase commands set their bits in any order and restart the window count. The window closes on the WINDOW_US-th tick after the last accepted command.
- R4: When the window closes, eraseStart is high for exactly one cycle, windowExpired goes high, and sectorMask keeps the queued bits.
- R5: A foreign command while the window is open clears sectorMask, drops busy and gives a one-cycle readMode pulse. It takes priority over a suspend or a sector erase command in the same cycle.
- R6: An erase suspend while the window is open sets suspended on the next cycle, with no eraseStart, windowExpired high and busy low.
- R7: An erase suspend during a running erase sets suspended on the SUSPEND_US-th tick after the command. Busy stays high until then.
- R8: While the erase runs, sector erase, foreign and resume commands have no effect: sectorMask, busy and suspended stay as they were.
- R9: An erase resume while suspended drops suspended, raises busy and gives a one-cycle eraseStart with sectorMask unchanged.
- R10: While suspended, accessDenied is high in the same cycle when accessReq targets a sector whose bit is set in sectorMask, and low for other sectors. It is low whenever the block is not suspended.
- R11: Engine completion (eraseDone), during the erase or while a suspend is pending, clears sectorMask, busy and windowExpired and gives a one-cycle readMode pulse.
- R12: While suspended, foreign, suspend and sector erase commands are ignored: suspended stays high and sectorMask is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickUs | input | 1 | One-cycle pulse each microsecond |
| cmdSectErase | input | 1 | Decoded sector erase command |
| cmdSectIdx | input | SECT_W | Sector index for cmdSectErase |
| cmdSuspend | input | 1 | Decoded erase suspend command |
| cmdResume | input | 1 | Decoded erase resume command |
| cmdOther | input | 1 | Any other decoded command |
| accessReq | input | 1 | Array read or program request |
| accessIdx | input | SECT_W | Sector targeted by accessReq |
| eraseDone | input | 1 | Erase engine finished |
| sectorMask | output | NUM_SECTORS | Queued sector bitmap |
| eraseStart | output | 1 | One-cycle erase start or restart |
| suspended | output | 1 | Erase is suspended |
| windowExpired | output | 1 | Acceptance window has closed |
| busy | output | 1 | Window open or erase running |
| readMode | output | 1 | One-cycle return-to-read pulse |
| accessDenied | output | 1 | Access targets a queued sector while suspended |

## Verification
The bench builds the block with NUM_SECTORS=8, WINDOW_US=4 and SUSPEND_US=3. With these values a window restart, the exact tick on which the window closes, and the full suspend latency each take only a handful of ticks, so each can be checked cycle by cycle. Eight sectors are enough to queue bits out of order, and to check denied and allowed accesses against the same mask.

// File: rtl/seq_pkg.sv
package seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_WINDOW   = 3'd1,
    ST_ERASING  = 3'd2,
    ST_SUSPPEND = 3'd3,
    ST_SUSP     = 3'd4
  } seqState_t;

  typedef struct packed {
    logic maskAdd;
    logic maskClear;
    logic winRestart;
    logic winRun;
    logic suspRestart;
    logic suspRun;
    logic inSuspend;
  } dpStrobe_t;

endpackage

// File: rtl/seq_datapath.sv
module seq_datapath
  import seq_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int WINDOW_US   = 50,
  parameter int SUSPEND_US  = 20,
  localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1,
  localparam int WIN_W  = (WINDOW_US > 1) ? $clog2(WINDOW_US) : 1,
  localparam int SUS_W  = (SUSPEND_US > 1) ? $clog2(SUSPEND_US) : 1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic                   tickUs,
  input  logic [SECT_W-1:0]      sectIdx,
  input  logic                   accessReq,
  input  logic [SECT_W-1:0]      accessIdx,
  output logic [NUM_SECTORS-1:0] mask,
  output logic                   winDone,
  output logic                   suspDone,
  output logic                   accessDenied
);

  localparam logic [WIN_W-1:0] WIN_MAX = WIN_W'(WINDOW_US - 1);
  localparam logic [SUS_W-1:0] SUS_MAX = SUS_W'(SUSPEND_US - 1);

  logic [WIN_W-1:0] winCnt;
  logic [SUS_W-1:0] suspCnt;
  logic [NUM_SECTORS-1:0] maskNext;

  // one register bit per sector
  for (genvar g = 0; g < NUM_SECTORS; g++) begin : gSect
    always_comb begin
      if (strb.maskClear)
        maskNext[g] = 1'b0;
      else if (strb.maskAdd && (int'(sectIdx) == g))
        maskNext[g] = 1'b1;
      else
        maskNext[g] = mask[g];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mask <= '0;
    else       mask <= maskNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      winCnt <= '0;
    else if (strb.winRestart)
      winCnt <= '0;
    else if (strb.winRun && tickUs && winCnt != WIN_MAX)
      winCnt <= winCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      suspCnt <= '0;
    else if (strb.suspRestart)
      suspCnt <= '0;
    else if (strb.suspRun && tickUs && suspCnt != SUS_MAX)
      suspCnt <= suspCnt + 1'b1;
  end

  assign winDone  = strb.winRun && tickUs && (winCnt == WIN_MAX);
  assign suspDone = strb.suspRun && tickUs && (suspCnt == SUS_MAX);

  assign accessDenied = strb.inSuspend && accessReq &&
                        (int'(accessIdx) < NUM_SECTORS) && mask[accessIdx];

  AST_WIN_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    winCnt <= WIN_MAX); // R3
  AST_MASK_ADD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.maskAdd && !strb.maskClear) |=> mask[$past(sectIdx)]); // R3
  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.maskAdd && !strb.maskClear) |=> $stable(mask)); // R8

endmodule

// File: rtl/seq_control.sv
module seq_control
  import seq_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      cmdSectErase,
  input  logic      cmdSuspend,
  input  logic      cmdResume,
  input  logic      cmdOther,
  input  logic      eraseDone,
  input  logic      winDone,
  input  logic      suspDone,
  output dpStrobe_t strb,
  output logic      eraseStart,
  output logic      suspended,
  output logic      windowExpired,
  output logic      busy,
  output logic      readMode
);

  seqState_t state, stateNext;
  logic startNext, readNext, expNext;

  always_comb begin
    stateNext = state;
    strb      = '0;
    startNext = 1'b0;
    readNext  = 1'b0;
    strb.winRun    = (state == ST_WINDOW);
    strb.suspRun   = (state == ST_SUSPPEND);
    strb.inSuspend = (state == ST_SUSP);
    unique case (state)
      ST_IDLE: begin
        if (cmdSectErase) begin
          stateNext       = ST_WINDOW;
          strb.maskAdd    = 1'b1;
          strb.winRestart = 1'b1;
        end
      end
      ST_WINDOW: begin
        if (cmdOther) begin
          stateNext      = ST_IDLE;
          strb.maskClear = 1'b1;
          readNext       = 1'b1;
        end else if (cmdSuspend) begin
          stateNext = ST_SUSP;
        end else if (cmdSectErase) begin
          strb.maskAdd    = 1'b1;
          strb.winRestart = 1'b1;
        end else if (winDone) begin
          stateNext = ST_ERASING;
          startNext = 1'b1;
        end
      end
      ST_ERASING: begin
        if (eraseDone) begin
          stateNext      = ST_IDLE;
          strb.maskClear = 1'b1;
          readNext       = 1'b1;
        end else if (cmdSuspend) begin
          stateNext        = ST_SUSPPEND;
          strb.suspRestart = 1'b1;
        end
      end
      ST_SUSPPEND: begin
        if (eraseDone) begin
          stateNext      = ST_IDLE;
          strb.maskClear = 1'b1;
          readNext       = 1'b1;
        end else if (suspDone) begin
          stateNext = ST_SUSP;
        end
      end
      ST_SUSP: begin
        if (cmdResume) begin
          stateNext = ST_ERASING;
          startNext = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
    expNext = (stateNext != ST_IDLE) && (stateNext != ST_WINDOW);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state         <= ST_IDLE;
      eraseStart    <= 1'b0;
      readMode      <= 1'b0;
      windowExpired <= 1'b0;
    end else begin
      state         <= stateNext;
      eraseStart    <= startNext;
      readMode      <= readNext;
      windowExpired <= expNext;
    end
  end

  assign suspended = (state == ST_SUSP);
  assign busy      = (state == ST_WINDOW) || (state == ST_ERASING) ||
                     (state == ST_SUSPPEND);

  AST_ABORT_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && cmdOther) |=> (state == ST_IDLE && readMode)); // R5
  AST_SUSPEND_FAST: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WINDOW && cmdSuspend && !cmdOther) |=> (suspended && !eraseStart)); // R6
  AST_RESUME_START: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_SUSP && cmdResume) |=> (eraseStart && busy)); // R9
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    eraseStart |=> !eraseStart); // R4
  AST_SUSP_IDLEBUS: assert property (@(posedge clk) disable iff (!rstN)
    suspended |-> !busy); // R12
  AST_DONE_READ: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ERASING && eraseDone) |=> (readMode && !busy)); // R11

endmodule

// File: rtl/sect_erase_queue.sv
module sect_erase_queue
  import seq_pkg::*;
#(
  parameter int NUM_SECTORS = 16,
  parameter int WINDOW_US   = 50,
  parameter int SUSPEND_US  = 20,
  localparam int SECT_W = (NUM_SECTORS > 1) ? $clog2(NUM_SECTORS) : 1
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   tickUs,
  input  logic                   cmdSectErase,
  input  logic [SECT_W-1:0]      cmdSectIdx,
  input  logic                   cmdSuspend,
  input  logic                   cmdResume,
  input  logic                   cmdOther,
  input  logic                   accessReq,
  input  logic [SECT_W-1:0]      accessIdx,
  input  logic                   eraseDone,
  output logic [NUM_SECTORS-1:0] sectorMask,
  output logic                   eraseStart,
  output logic                   suspended,
  output logic                   windowExpired,
  output logic                   busy,
  output logic                   readMode,
  output logic                   accessDenied
);

  dpStrobe_t strb;
  logic winDone, suspDone;

  seq_control uCtrl (
    .clk(clk), .rstN(rstN),
    .cmdSectErase(cmdSectErase), .cmdSuspend(cmdSuspend),
    .cmdResume(cmdResume), .cmdOther(cmdOther), .eraseDone(eraseDone),
    .winDone(winDone), .suspDone(suspDone), .strb(strb),
    .eraseStart(eraseStart), .suspended(suspended),
    .windowExpired(windowExpired), .busy(busy), .readMode(readMode)
  );

  seq_datapath #(
    .NUM_SECTORS(NUM_SECTORS), .WINDOW_US(WINDOW_US), .SUSPEND_US(SUSPEND_US)
  ) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .tickUs(tickUs),
    .sectIdx(cmdSectIdx), .accessReq(accessReq), .accessIdx(accessIdx),
    .mask(sectorMask), .winDone(winDone), .suspDone(suspDone),
    .accessDenied(accessDenied)
  );

endmodule

// File: tb/sect_erase_queue_test.sv
module sect_erase_queue_test;

  localparam int NS = 8;
  localparam int WU = 4;
  localparam int SU = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickUs = 0, cmdSectErase = 0, cmdSuspend = 0, cmdResume = 0, cmdOther = 0;
  logic accessReq = 0, eraseDone = 0;
  logic [2:0] cmdSectIdx = '0, accessIdx = '0;
  logic [NS-1:0] sectorMask;
  logic eraseStart, suspended, windowExpired, busy, readMode, accessDenied;

  int nChecks = 0;
  int nFails = 0;

  always #5 clk = ~clk;

  sect_erase_queue #(.NUM_SECTORS(NS), .WINDOW_US(WU), .SUSPEND_US(SU)) uut (
    .clk(clk), .rstN(rstN), .tickUs(tickUs), .cmdSectErase(cmdSectErase),
    .cmdSectIdx(cmdSectIdx), .cmdSuspend(cmdSuspend), .cmdResume(cmdResume),
    .cmdOther(cmdOther), .accessReq(accessReq), .accessIdx(accessIdx),
    .eraseDone(eraseDone), .sectorMask(sectorMask), .eraseStart(eraseStart),
    .suspended(suspended), .windowExpired(windowExpired), .busy(busy),
    .readMode(readMode), .accessDenied(accessDenied)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // status word: {eraseStart, suspended, windowExpired, busy, readMode}
  function automatic logic [31:0] stat();
    return {27'd0, eraseStart, suspended, windowExpired, busy, readMode};
  endfunction

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic clearIn();
    tickUs = 0; cmdSectErase = 0; cmdSuspend = 0; cmdResume = 0;
    cmdOther = 0; eraseDone = 0;
  endtask

  task automatic sectCmd(int idx);
    cmdSectErase = 1; cmdSectIdx = 3'(idx); cyc(); clearIn();
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      tickUs = 1; cyc(); clearIn();
    end
  endtask

  task automatic tReset();
    check("R1 mask", 32'(sectorMask), 0);
    check("R1 status", stat(), 0);
    check("R1 deny", 32'(accessDenied), 0);
  endtask

  task automatic tWindowExpiry();
    sectCmd(5);
    check("R2 mask", 32'(sectorMask), 32'h20);
    check("R2 status busy", stat(), 32'b00010);
    ticks(WU - 1);
    sectCmd(2);
    check("R3 mask", 32'(sectorMask), 32'h24);
    ticks(WU - 1);
    check("R3 still open", stat(), 32'b00010);
    ticks(1);
    check("R4 start", stat(), 32'b10110);
    check("R4 mask", 32'(sectorMask), 32'h24);
    cyc();
    check("R4 pulse ends", stat(), 32'b00110);
    cmdOther = 1; cyc(); clearIn();
    cmdSectErase = 1; cmdSectIdx = 3'd7; cyc(); clearIn();
    cmdResume = 1; cyc(); clearIn();
    check("R8 mask", 32'(sectorMask), 32'h24);
    check("R8 status", stat(), 32'b00110);
    eraseDone = 1; cyc(); clearIn();
    check("R11 done", stat(), 32'b00001);
    check("R11 mask", 32'(sectorMask), 0);
    cyc();
    check("R11 pulse ends", stat(), 0);
  endtask

  task automatic tAbort();
    sectCmd(1);
    ticks(2);
    cmdOther = 1; cmdSuspend = 1; cmdSectErase = 1; cmdSectIdx = 3'd4;
    cyc(); clearIn();
    check("R5 mask", 32'(sectorMask), 0);
    check("R5 status", stat(), 32'b00001);
    ticks(WU + 1);
    check("R5 no start", stat(), 0);
  endtask

  task automatic tSuspendWindow();
    sectCmd(3);
    ticks(1);
    cmdSuspend = 1; cyc(); clearIn();
    check("R6 status", stat(), 32'b01100);
    accessReq = 1; accessIdx = 3'd3; #1;
    check("R10 denied", 32'(accessDenied), 1);
    accessIdx = 3'd4; #1;
    check("R10 allowed", 32'(accessDenied), 0);
    accessReq = 0;
    cmdOther = 1; cyc(); clearIn();
    cmdSuspend = 1; cmdSectErase = 1; cmdSectIdx = 3'd0; cyc(); clearIn();
    check("R12 status", stat(), 32'b01100);
    check("R12 mask", 32'(sectorMask), 32'h08);
    cmdResume = 1; cyc(); clearIn();
    check("R9 status", stat(), 32'b10110);
    check("R9 mask", 32'(sectorMask), 32'h08);
    accessReq = 1; accessIdx = 3'd3; #1;
    check("R10 not suspended", 32'(accessDenied), 0);
    accessReq = 0;
  endtask

  task automatic tSuspendErase();
    cmdSuspend = 1; cyc(); clearIn();
    check("R7 pending", stat(), 32'b00110);
    ticks(SU - 1);
    check("R7 still pending", stat(), 32'b00110);
    ticks(1);
    check("R7 suspended", stat(), 32'b01100);
    cmdResume = 1; cyc(); clearIn();
    cmdSuspend = 1; cyc(); clearIn();
    ticks(1);
    eraseDone = 1; cyc(); clearIn();
    check("R11 done while pending", stat(), 32'b00001);
    check("R11 mask pending", 32'(sectorMask), 0);
  endtask

  initial begin
    repeat (3) cyc();
    rstN = 1;
    cyc();
    tReset();
    tWindowExpiry();
    tAbort();
    tSuspendWindow();
    tSuspendErase();
    cyc();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    nChecks++;
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule